// File: doc/BRIEF.md
# Free-running 64-bit time counter with snapshot registers

The block keeps a 64-bit counter that advances by one on every clock cycle in which the count-enable input is high. Software sees the counter only through a pair of 32-bit snapshot words. It takes a coherent copy by writing a latch command to a control word. The whole 64-bit value is captured on one clock edge, so the two halves never come from different counts. A clear command zeroes both snapshot words. Software may also write either snapshot word directly.

Both command bits are one-shot. They act on the write that carries them and always read back as 0. A control write may carry both commands. The latch is applied first and the clear after it, so the snapshot words end at zero. The control bits that are not commands are kept exactly as written.

The register port is a simple single-cycle request interface. A write takes effect at the clock edge where `req_i` and `we_i` are high. Read data is combinational from `addr_i` and reflects the register state after the most recent edge.

Top module: `free_counter_snap`

## Requirements
- R1: After reset is released, reads of the low word (address 0), the high word (address 1) and the control word (address 2) all return 0.
- R2: The internal counter increases by one at each clock edge where `count_en_i` is 1, holds its value when `count_en_i` is 0, and wraps modulo 2^64. Reset clears it to 0.
- R3: A write to address 2 with bit 1 set and bit 0 clear copies the counter value held in that cycle, before that edge's increment, into the low word (counter bits 31:0) and the high word (counter bits 63:32).
- R4: Bit 1 of the control word (latch) always reads back as 0, including directly after a write that set it.
- R5: A write to address 2 with bit 0 set zeroes the low and high words, and bit 0 of the control word reads back as 0 afterwards.
- R6: A write to address 2 with both bit 1 and bit 0 set leaves the low and high words at 0.
- R7: A write to address 0 or address 1 stores `wdata_i` in the low or high word, and a later read returns that value.
- R8: On a write to address 2, control bits 31:2 are stored as written and read back unchanged.
- R9: A write to an unmapped address (3) changes no register. A cycle with `req_i` low changes no register, whatever the values of `we_i`, `addr_i` and `wdata_i`. A read of address 3 returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| count_en_i | input | 1 | Counter advances on edges where this is high |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | Write when high, read when low |
| addr_i | input | ADDR_W (2) | Word address: 0 low, 1 high, 2 control |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` (combinational) |

## Verification
A latch command can land in the same cycle as a counter increment, and a latch can coincide with a clear in a single control write. The bench provokes the first case by issuing latch writes while `count_en_i` is high. It checks that the snapshot holds the pre-increment count, which it takes from a behavioural counter model. It provokes the second case by loading non-zero snapshot words and then writing both command bits at once. The result is judged correct only when both words read zero and the control bits above the commands are kept.

// File: rtl/fcs_pkg.sv
package fcs_pkg;
  localparam int unsigned REG_W       = 32;
  localparam int unsigned CMD_CLR_BIT = 0;
  localparam int unsigned CMD_LAT_BIT = 1;

  typedef logic [REG_W-1:0] word_t;

  // command bits are never stored
  localparam word_t CMD_MASK = word_t'((1 << CMD_CLR_BIT) | (1 << CMD_LAT_BIT));
endpackage

// File: rtl/fcs_counter.sv
module fcs_counter #(
  parameter int unsigned CNT_W = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cnt_q <= '0;
    else if (en_i) cnt_q <= cnt_q + CNT_W'(1);
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/fcs_decode.sv
module fcs_decode #(
  parameter int unsigned ADDR_W = 2,
  parameter int unsigned NUM_W  = 2
) (
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [NUM_W-1:0]  wr_word_o,
  output logic              wr_ctl_o,
  output logic [NUM_W-1:0]  rd_word_o,
  output logic              rd_ctl_o
);
  localparam logic [ADDR_W-1:0] CTL_ADDR = ADDR_W'(NUM_W);

  logic wr;
  assign wr = req_i & we_i;

  for (genvar j = 0; j < NUM_W; j++) begin : g_word
    assign rd_word_o[j] = (addr_i == ADDR_W'(j));
    assign wr_word_o[j] = wr & rd_word_o[j];
  end

  assign rd_ctl_o = (addr_i == CTL_ADDR);
  assign wr_ctl_o = wr & rd_ctl_o;
endmodule

// File: rtl/fcs_snap.sv
module fcs_snap
  import fcs_pkg::*;
#(
  parameter int unsigned CNT_W = 64,
  parameter int unsigned NUM_W = CNT_W / REG_W
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [CNT_W-1:0]           cnt_i,
  input  logic [NUM_W-1:0]           wr_word_i,
  input  logic                       wr_ctl_i,
  input  word_t                      wdata_i,
  output logic [NUM_W-1:0][REG_W-1:0] words_o,
  output word_t                      ctl_o
);
  logic do_clr, do_lat;
  word_t ctl_q;

  assign do_clr = wr_ctl_i & wdata_i[CMD_CLR_BIT];
  assign do_lat = wr_ctl_i & wdata_i[CMD_LAT_BIT];

  for (genvar j = 0; j < NUM_W; j++) begin : g_word
    word_t word_q;
    // latch first, clear last: clear wins
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)           word_q <= '0;
      else if (do_clr)       word_q <= '0;
      else if (do_lat)       word_q <= cnt_i[j*REG_W +: REG_W];
      else if (wr_word_i[j]) word_q <= wdata_i;
    end
    assign words_o[j] = word_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ctl_q <= '0;
    else if (wr_ctl_i) ctl_q <= wdata_i & ~CMD_MASK;
  end

  assign ctl_o = ctl_q;
endmodule

// File: rtl/free_counter_snap.sv
module free_counter_snap
  import fcs_pkg::*;
#(
  parameter int unsigned CNT_W  = 64,
  parameter int unsigned ADDR_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              count_en_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o
);
  localparam int unsigned NUM_W = CNT_W / REG_W;

  logic [CNT_W-1:0]            cnt_q;
  logic [NUM_W-1:0]            wr_word, rd_word;
  logic                        wr_ctl, rd_ctl;
  logic [NUM_W-1:0][REG_W-1:0] words_q;
  word_t                       ctl_q;

  fcs_counter #(.CNT_W(CNT_W)) i_counter (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (count_en_i),
    .cnt_o (cnt_q)
  );

  fcs_decode #(.ADDR_W(ADDR_W), .NUM_W(NUM_W)) i_decode (
    .req_i    (req_i),
    .we_i     (we_i),
    .addr_i   (addr_i),
    .wr_word_o(wr_word),
    .wr_ctl_o (wr_ctl),
    .rd_word_o(rd_word),
    .rd_ctl_o (rd_ctl)
  );

  fcs_snap #(.CNT_W(CNT_W), .NUM_W(NUM_W)) i_snap (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cnt_i    (cnt_q),
    .wr_word_i(wr_word),
    .wr_ctl_i (wr_ctl),
    .wdata_i  (wdata_i),
    .words_o  (words_q),
    .ctl_o    (ctl_q)
  );

  always_comb begin
    rdata_o = rd_ctl ? ctl_q : '0;
    for (int j = 0; j < NUM_W; j++) begin
      if (rd_word[j]) rdata_o = words_q[j];
    end
  end
endmodule

// File: rtl/fcs_checker.sv
module fcs_checker #(
  parameter int unsigned CNT_W  = 64,
  parameter int unsigned ADDR_W = 2
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 count_en_i,
  input logic                 req_i,
  input logic                 we_i,
  input logic [ADDR_W-1:0]    addr_i,
  input logic [31:0]          wdata_i,
  input logic [CNT_W-1:0]     cnt_q,
  input logic [CNT_W/32-1:0][31:0] words_q,
  input logic [31:0]          ctl_q
);
  localparam int unsigned NUM_W = CNT_W / 32;

  logic wr_any, wr_ctl, wr_lo;
  assign wr_any = req_i && we_i;
  assign wr_ctl = wr_any && (addr_i == ADDR_W'(NUM_W));
  assign wr_lo  = wr_any && (addr_i == ADDR_W'(0));

  p_count_up_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_en_i |=> cnt_q == $past(cnt_q) + CNT_W'(1));

  p_count_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !count_en_i |=> $stable(cnt_q));

  p_latch_lo_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ctl && wdata_i[1] && !wdata_i[0]) |=> words_q[0] == $past(cnt_q[31:0]));

  p_latch_hi_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ctl && wdata_i[1] && !wdata_i[0]) |=> words_q[NUM_W-1] == $past(cnt_q[CNT_W-1 -: 32]));

  p_cmd_self_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ctl |=> ctl_q[1:0] == 2'b00);

  p_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ctl && wdata_i[0]) |=> (words_q == '0));

  p_both_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ctl && wdata_i[1] && wdata_i[0]) |=> (words_q == '0));

  p_direct_lo_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_lo |=> words_q[0] == $past(wdata_i));

  p_ctl_upper_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ctl |=> ctl_q[31:2] == $past(wdata_i[31:2]));

  p_no_write_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_any && (addr_i <= ADDR_W'(NUM_W))) |=> ($stable(words_q) && $stable(ctl_q)));
endmodule

bind free_counter_snap fcs_checker #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) i_fcs_checker (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .count_en_i(count_en_i),
  .req_i     (req_i),
  .we_i      (we_i),
  .addr_i    (addr_i),
  .wdata_i   (wdata_i),
  .cnt_q     (cnt_q),
  .words_q   (words_q),
  .ctl_q     (ctl_q)
);

// File: tb/test_free_counter_snap.sv
`timescale 1ns/1ps
module test_free_counter_snap;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        count_en = 1'b0;
  logic        req = 1'b0;
  logic        we = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  // reference model state
  longint unsigned m_cnt = 0;
  logic [31:0] m_lo = '0, m_hi = '0, m_ctl = '0;

  always #4 clk = ~clk;

  free_counter_snap i_free_counter_snap (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .count_en_i(count_en),
    .req_i     (req),
    .we_i      (we),
    .addr_i    (addr),
    .wdata_i   (wdata),
    .rdata_o   (rdata)
  );

  function automatic logic [31:0] m_read(input logic [1:0] a);
    case (a)
      2'd0:    return m_lo;
      2'd1:    return m_hi;
      2'd2:    return m_ctl;
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s addr=%0d actual=%h expected=%h", tag, addr, act, exp);
    end
  endtask

  // one clock: drive at negedge, compare read, update model at posedge
  task automatic cyc(input logic rq, input logic w, input logic [1:0] a,
                     input logic [31:0] d, input logic en, input string tag);
    @(negedge clk);
    req = rq; we = w; addr = a; wdata = d; count_en = en;
    #1;
    check(tag, rdata, m_read(a));
    @(posedge clk);
    if (rq && w) begin
      case (a)
        2'd0: m_lo = d;
        2'd1: m_hi = d;
        2'd2: begin
          if (d[1]) begin m_lo = m_cnt[31:0]; m_hi = m_cnt[63:32]; end
          if (d[0]) begin m_lo = 0; m_hi = 0; end
          m_ctl = d & 32'hFFFF_FFFC;
        end
        default: ;
      endcase
    end
    if (en) m_cnt = m_cnt + 1;
  endtask

  task automatic rd(input logic [1:0] a, input logic en, input string tag);
    cyc(1'b1, 1'b0, a, 32'h0, en, tag);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d, input logic en, input string tag);
    cyc(1'b1, 1'b1, a, d, en, tag);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    rd(2'd0, 1'b0, "R1"); rd(2'd1, 1'b0, "R1"); rd(2'd2, 1'b0, "R1");

    // R2 count with mixed enable, then R3 latch during an increment
    for (int i = 0; i < 12; i++) cyc(1'b0, 1'b0, 2'd0, 32'h0, (i % 3) != 0, "R2");
    wr(2'd2, 32'h0000_0002, 1'b1, "R2");
    rd(2'd0, 1'b1, "R3"); rd(2'd1, 1'b0, "R3"); rd(2'd2, 1'b1, "R4");

    // R2 enable held low, latch while stopped
    for (int i = 0; i < 5; i++) cyc(1'b0, 1'b0, 2'd0, 32'h0, 1'b0, "R2");
    wr(2'd2, 32'h0000_0002, 1'b0, "R3");
    rd(2'd0, 1'b0, "R2"); rd(2'd1, 1'b0, "R3");

    // R7 direct writes
    wr(2'd0, 32'hA5A5_5A5A, 1'b1, "R7");
    wr(2'd1, 32'h1234_5678, 1'b1, "R7");
    rd(2'd0, 1'b1, "R7"); rd(2'd1, 1'b1, "R7");

    // R9 unmapped write, write without req
    wr(2'd3, 32'hFFFF_FFFF, 1'b1, "R9");
    rd(2'd3, 1'b1, "R9");
    cyc(1'b0, 1'b1, 2'd0, 32'hDEAD_BEEF, 1'b1, "R9");
    cyc(1'b0, 1'b1, 2'd2, 32'hFFFF_FFFF, 1'b1, "R9");
    rd(2'd0, 1'b1, "R9"); rd(2'd1, 1'b1, "R9"); rd(2'd2, 1'b1, "R9");

    // R5 clear
    wr(2'd2, 32'h0000_0001, 1'b1, "R5");
    rd(2'd0, 1'b1, "R5"); rd(2'd1, 1'b1, "R5"); rd(2'd2, 1'b1, "R5");

    // R6 latch and clear together, with upper bits R8
    wr(2'd0, 32'h0BAD_F00D, 1'b1, "R7");
    wr(2'd1, 32'h7777_0001, 1'b1, "R7");
    wr(2'd2, 32'hC000_0003, 1'b1, "R6");
    rd(2'd0, 1'b1, "R6"); rd(2'd1, 1'b1, "R6"); rd(2'd2, 1'b1, "R8");

    // R8 upper bits kept alongside a latch, R4 latch bit reads 0
    for (int i = 0; i < 7; i++) cyc(1'b0, 1'b0, 2'd0, 32'h0, 1'b1, "R2");
    wr(2'd2, 32'hF0F0_00F6, 1'b1, "R8");
    rd(2'd2, 1'b1, "R8"); rd(2'd0, 1'b1, "R3"); rd(2'd1, 1'b1, "R3");
    wr(2'd2, 32'h0000_0004, 1'b1, "R8");
    rd(2'd2, 1'b1, "R4");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule